// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the programmer-visible registers of a small 16-bit CPU core. Seven registers are banked: four data registers, two address registers and a frame base. There are two copies of this group, and a bank bit in the flag register picks which copy is live. A static base, two stack pointers, the flag register, a 20-bit program counter and a 20-bit interrupt table base exist only once and are reached the same way in either bank.

Two combinational read ports and one synchronous write port each take a 5-bit register selector and a 2-bit size code. The size code is 0 for a byte, 1 for a word, 2 for a 32-bit long, and 3 is handled as a word. Depending on the size, one selector reaches a byte, a word or a register pair. The flag register is also driven out on its own port, so the core sees the bank, the stack select and the condition bits without a read.

Selector codes are: 0 D0, 1 D1, 2 D2, 3 D3, 4 X0, 5 X1, 6 FRM, 7 SBASE, 8 ISTK, 9 USTK, 10 FLAGS, 11 PCNT, 12 IVBASE, 13 SP (the active stack pointer). Codes 14 to 31 are unused.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register in both banks, every shared register and the flag output are zero. The live bank is therefore bank 0 and the active stack pointer is ISTK.
- R2: A word write stores wr_data[15:0] into the selected register at the next rising edge. A word read returns that value zero-extended to 32 bits. Either read port can read any selector independently. Unused selectors read 0 and ignore writes.
- R3: Byte views: with size 0, selectors 0 and 1 address the low bytes of D0 and D1, and selectors 2 and 3 address their high bytes. Any other selector addresses the low byte of its register. A byte write changes only the addressed byte. A byte read is zero-extended.
- R4: Long views: selector 0 is {D2,D0}, selector 1 is {D3,D1} and selector 4 is {X1,X0}, with the second register named in the upper half. A long write to one of these updates both halves in the same edge. Other selectors treat a long access as a word, except PCNT and IVBASE (R9).
- R5: Flag bit 4 selects the bank for D0 to D3, X0, X1 and FRM. A banked write goes to the bank selected before that edge and leaves the other bank unchanged.
- R6: SBASE, ISTK, USTK, FLAGS, PCNT and IVBASE hold a single value that is seen from both banks.
- R7: FLAGS bits are C=0, D=1, Z=2, S=3, B=4, O=5, I=6 and U=7, with the priority level in bits 14:12. All other bits read 0 and ignore writes. The flg output always equals FLAGS.
- R8: Selector 13 reads and writes ISTK when flag bit 7 (U) is 0, and USTK when U is 1. The stack pointer that is not selected is left unchanged.
- R9: PCNT and IVBASE are 20 bits wide. A long write loads wr_data[19:0] and drops the upper bits. A word write replaces bits 15:0 and keeps bits 19:16. A long read returns the 20-bit value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_sel | input | 5 | Read port 0 register selector |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 data |
| rd1_sel | input | 5 | Read port 1 register selector |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Write register selector |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data |
| flg | output | 16 | Current flag register |

## Verification
The assertions assume that wr_sel, wr_size and wr_en hold known values at every sampled edge after reset. The "other bank unchanged" and "low byte kept" properties also rely on the single write port: in the cycle where they are checked, the bank bit cannot move. The stimulus respects this. It drives only defined size codes and holds wr_en low during reset. It never overlaps a read check with a write, so every sampled read reflects the state after the previous edge.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd0_sel,
  input  logic [1:0]    rd0_size,
  output logic [2*DW-1:0] rd0_data,
  input  logic [SW-1:0] rd1_sel,
  input  logic [1:0]    rd1_size,
  output logic [2*DW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [1:0]    wr_size,
  input  logic [2*DW-1:0] wr_data,
  output logic [DW-1:0] flg
);
  localparam int LW = 2 * DW;
  localparam int NB = 7;
  localparam logic [1:0] SZ_B = 2'd0, SZ_L = 2'd2;
  localparam logic [SW-1:0] S_D0 = 0, S_D1 = 1, S_D2 = 2, S_D3 = 3, S_X0 = 4,
    S_X1 = 5, S_FRM = 6, S_SB = 7, S_ISP = 8, S_USP = 9, S_FLG = 10,
    S_PC = 11, S_IVB = 12, S_SP = 13;
  localparam logic [DW-1:0] FLG_MASK = 16'h70FF;

  logic [DW-1:0] gpr [2][NB];
  logic [DW-1:0] sb, isp, usp, flg_q;
  logic [AW-1:0] pc, ivb;

  wire bk   = flg_q[4];
  wire usel = flg_q[7];
  assign flg = flg_q;

  function automatic logic [DW-1:0] put16(input logic [DW-1:0] o, input logic [1:0] z,
                                          input logic [LW-1:0] d);
    return (z == SZ_B) ? {o[DW-1:8], d[7:0]} : d[DW-1:0];
  endfunction

  function automatic logic [AW-1:0] put20(input logic [AW-1:0] o, input logic [1:0] z,
                                          input logic [LW-1:0] d);
    if (z == SZ_B) return {o[AW-1:8], d[7:0]};
    if (z == SZ_L) return d[AW-1:0];
    return {o[AW-1:DW], d[DW-1:0]};
  endfunction

  logic [SW-1:0] psel [2];
  logic [1:0]    psz  [2];
  logic [LW-1:0] pdat [2];
  assign psel[0] = rd0_sel;  assign psz[0] = rd0_size;
  assign psel[1] = rd1_sel;  assign psz[1] = rd1_size;
  assign rd0_data = pdat[0];
  assign rd1_data = pdat[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DW-1:0] w;
    always_comb begin
      w = '0;
      if (psel[p] < SW'(NB)) w = gpr[bk][psel[p][2:0]];
      else case (psel[p])
        S_SB:  w = sb;
        S_ISP: w = isp;
        S_USP: w = usp;
        S_FLG: w = flg_q;
        S_PC:  w = pc[DW-1:0];
        S_IVB: w = ivb[DW-1:0];
        S_SP:  w = usel ? usp : isp;
        default: w = '0;
      endcase
      pdat[p] = {{DW{1'b0}}, w};
      if (psz[p] == SZ_B) begin
        if (psel[p] == S_D2 || psel[p] == S_D3)
          pdat[p] = {{(LW-8){1'b0}}, gpr[bk][{2'b00, psel[p][0]}][DW-1:8]};
        else
          pdat[p] = {{(LW-8){1'b0}}, w[7:0]};
      end else if (psz[p] == SZ_L) begin
        case (psel[p])
          S_D0:  pdat[p] = {gpr[bk][2], gpr[bk][0]};
          S_D1:  pdat[p] = {gpr[bk][3], gpr[bk][1]};
          S_X0:  pdat[p] = {gpr[bk][5], gpr[bk][4]};
          S_PC:  pdat[p] = {{(LW-AW){1'b0}}, pc};
          S_IVB: pdat[p] = {{(LW-AW){1'b0}}, ivb};
          default: ;
        endcase
      end
    end
  end

  wire [2:0] wi = wr_sel[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < NB; r++) gpr[b][r] <= '0;
      sb <= '0; isp <= '0; usp <= '0; flg_q <= '0; pc <= '0; ivb <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        S_D0, S_D1:
          if (wr_size == SZ_L) begin
            gpr[bk][wi]        <= wr_data[DW-1:0];
            gpr[bk][wi + 3'd2] <= wr_data[LW-1:DW];
          end else gpr[bk][wi] <= put16(gpr[bk][wi], wr_size, wr_data);
        S_D2, S_D3:
          if (wr_size == SZ_B) gpr[bk][{2'b00, wi[0]}][DW-1:8] <= wr_data[7:0];
          else gpr[bk][wi] <= wr_data[DW-1:0];
        S_X0:
          if (wr_size == SZ_L) begin
            gpr[bk][4] <= wr_data[DW-1:0];
            gpr[bk][5] <= wr_data[LW-1:DW];
          end else gpr[bk][4] <= put16(gpr[bk][4], wr_size, wr_data);
        S_X1, S_FRM: gpr[bk][wi] <= put16(gpr[bk][wi], wr_size, wr_data);
        S_SB:  sb    <= put16(sb, wr_size, wr_data);
        S_ISP: isp   <= put16(isp, wr_size, wr_data);
        S_USP: usp   <= put16(usp, wr_size, wr_data);
        S_FLG: flg_q <= put16(flg_q, wr_size, wr_data) & FLG_MASK;
        S_SP:
          if (usel) usp <= put16(usp, wr_size, wr_data);
          else      isp <= put16(isp, wr_size, wr_data);
        S_PC:  pc  <= put20(pc, wr_size, wr_data);
        S_IVB: ivb <= put20(ivb, wr_size, wr_data);
        default: ;
      endcase
    end
  end

  wire [NB*DW-1:0] idle_bank = {gpr[!bk][6], gpr[!bk][5], gpr[!bk][4], gpr[!bk][3],
                                gpr[!bk][2], gpr[!bk][1], gpr[!bk][0]};

  assert_flg_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg & ~FLG_MASK) == '0);

  assert_keep_low_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_B && wr_sel == S_D2) |=> gpr[bk][0][7:0] == $past(gpr[bk][0][7:0]));

  assert_pair_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_L && wr_sel == S_D0) |=> {gpr[bk][2], gpr[bk][0]} == $past(wr_data));

  assert_idle_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel < SW'(NB)) |=> $stable(idle_bank));

  assert_sp_alias_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == S_SP && !usel) |=> $stable(usp));

  assert_pc_trunc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == S_PC && wr_size == SZ_L) |=> pc == $past(wr_data[AW-1:0]));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd0_sel = 0, rd1_sel = 0, wr_sel = 0;
  logic [1:0] rd0_size = 1, rd1_size = 1, wr_size = 1;
  logic [31:0] rd0_data, rd1_data, wr_data = 0;
  logic wr_en = 0;
  logic [15:0] flg;
  logic chk_vld = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int port; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  localparam logic [1:0] B = 0, W = 1, L = 2;
  localparam logic [4:0] D0 = 0, D1 = 1, D2 = 2, D3 = 3, X0 = 4, X1 = 5, FRM = 6,
    SB = 7, ISP = 8, USP = 9, FLG = 10, PC = 11, IVB = 12, SP = 13;

  always #2 clk = ~clk;

  banked_regfile uut (.clk(clk), .rst_n(rst_n), .rd0_sel(rd0_sel), .rd0_size(rd0_size),
    .rd0_data(rd0_data), .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data), .flg(flg));

  task automatic wr(input logic [4:0] s, input logic [1:0] z, input logic [31:0] d);
    wr_sel = s; wr_size = z; wr_data = d; wr_en = 1; chk_vld = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int port, input logic [4:0] s, input logic [1:0] z,
                    input logic [31:0] e, input string tag);
    item_t it;
    if (port == 0) begin rd0_sel = s; rd0_size = z; end
    else if (port == 1) begin rd1_sel = s; rd1_size = z; end
    it.port = port; it.exp = e; it.tag = tag;
    q.push_back(it);
    chk_vld = 1;
    @(negedge clk);
    chk_vld = 0;
  endtask

  always @(posedge clk) begin
    if (chk_vld) begin
      item_t it;
      logic [31:0] got;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: empty queue, actual none expected item");
      end else begin
        it = q.pop_front();
        got = (it.port == 0) ? rd0_data : (it.port == 1) ? rd1_data : {16'h0, flg};
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s port%0d: actual %h expected %h", it.tag, it.port, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, D0, W, 0, "R1 reset D0");
    rd(1, USP, W, 0, "R1 reset USTK");
    rd(2, 0, W, 0, "R1 reset flg");

    wr(D0, W, 32'hFFFF1234);
    rd(0, D0, W, 32'h1234, "R2 word read p0");
    rd(1, D0, W, 32'h1234, "R2 word read p1");

    wr(D2, B, 32'hAB);
    rd(0, D0, W, 32'hAB34, "R3 high byte keeps low");
    rd(1, D0, B, 32'h34, "R3 low byte view");
    rd(0, D2, B, 32'hAB, "R3 high byte view");
    wr(D1, B, 32'h3C);
    wr(D3, B, 32'hC3);
    rd(0, D1, W, 32'hC33C, "R3 D1 bytes");

    wr(D0, L, 32'hCAFEBEEF);
    rd(0, D0, L, 32'hCAFEBEEF, "R4 long D2:D0");
    rd(1, D2, W, 32'hCAFE, "R4 upper half");
    rd(0, D1, L, 32'h0000C33C, "R4 long D3:D1");
    wr(X0, L, 32'h11112222);
    rd(0, X1, W, 32'h1111, "R4 X1");
    rd(1, X0, W, 32'h2222, "R4 X0");

    wr(SB, W, 32'h5A5A);
    wr(FRM, W, 32'h0F0F);
    wr(FLG, W, 32'h0010);
    rd(2, 0, W, 32'h0010, "R5 bank bit");
    rd(0, D0, W, 0, "R5 bank1 D0");
    rd(1, FRM, W, 0, "R5 bank1 FRM");
    wr(D0, W, 32'h7777);
    rd(0, D0, W, 32'h7777, "R5 bank1 write");
    rd(1, SB, W, 32'h5A5A, "R6 shared SBASE");
    wr(FLG, W, 0);
    rd(0, D0, W, 32'hBEEF, "R5 bank0 untouched");
    rd(1, FRM, W, 32'h0F0F, "R5 bank0 FRM");
    rd(0, SB, W, 32'h5A5A, "R6 shared after switch");

    wr(FLG, W, 32'hFFFF);
    rd(0, FLG, W, 32'h70FF, "R7 reserved read 0");
    rd(2, 0, W, 32'h70FF, "R7 flg port");
    wr(FLG, B, 32'h00);
    rd(0, FLG, W, 32'h7000, "R7 byte write keeps level");
    wr(FLG, W, 0);

    wr(SP, W, 32'h0400);
    rd(0, ISP, W, 32'h0400, "R8 SP to ISTK");
    rd(1, USP, W, 0, "R8 USTK untouched");
    wr(FLG, W, 32'h0080);
    wr(SP, W, 32'h0800);
    rd(0, USP, W, 32'h0800, "R8 SP to USTK");
    rd(1, ISP, W, 32'h0400, "R8 ISTK untouched");
    rd(0, SP, W, 32'h0800, "R8 SP read U=1");
    wr(FLG, W, 0);
    rd(1, SP, W, 32'h0400, "R8 SP read U=0");

    wr(PC, L, 32'hFFFABCDE);
    rd(0, PC, L, 32'h000ABCDE, "R9 PCNT long");
    wr(PC, W, 32'h1234);
    rd(0, PC, L, 32'h000A1234, "R9 PCNT word keeps top");
    wr(IVB, L, 32'h12345678);
    rd(1, IVB, L, 32'h00045678, "R9 IVBASE long");
    rd(0, IVB, W, 32'h5678, "R9 IVBASE word");

    wr(5'd20, W, 32'hFFFF);
    rd(0, 5'd20, W, 0, "R2 unused selector");
    rd(1, D0, W, 32'hBEEF, "R2 unused write ignored");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule